// File: doc/BRIEF.md
# Bit-Sliced Multi-Plane Crossbar Fabric

This block is a switch fabric for fixed-size cells. It raises the line rate by running several identical crossbar planes side by side. Each ingress cell is cut into equal slices, one for each plane. Every plane switches only its own slice, so the planes together behave as one wide switched bus.

A single input-to-output configuration steers all planes at once. The configuration gives, for each output, the input it takes its cell from and an enable bit. It is captured on a cell-start strobe and holds for the whole cell time, so one scheduling decision covers every slice of every cell. At each egress port the slices come back from all planes in the same cycle and are joined in plane order to rebuild the cell. Two outputs may name the same input, in which case both get a copy.

Top module: `bitslice_xbar`

## Requirements
- R1: Slice i of a cell is bits [i*CELL_W/N_PLANES +: CELL_W/N_PLANES]. Plane i carries only slice i, and each egress cell is rebuilt with slice i in the same bit position, so a cell with a distinct value in every slice comes out bit-identical.
- R2: The configuration inputs (`cfg_sel`, `cfg_en`) are captured only on a clock edge where `cell_start` is high. Changing them while `cell_start` is low has no effect on routing.
- R3: When output o is enabled, its select field `cfg_sel[o*SW +: SW]` names input s, and `in_valid[s]` is high, then one clock later `out_cell[o*CELL_W +: CELL_W]` equals the cell that was on input s and `out_valid[o]` is 1.
- R4: When the enable bit of output o in the held configuration is 0, that output drives an all-zero cell and a low valid one clock later.
- R5: When an enabled output selects an input whose `in_valid` is low, the output drives an all-zero cell and a low valid.
- R6: Several outputs may select the same input. Each of them receives the full cell in the same cycle.
- R7: Synchronous active-high reset clears the held configuration to all outputs disabled and drives every output cell and valid to zero.
- R8: The cell presented in the cycle whose edge captures a new configuration is still routed by the previous configuration. The new configuration applies from the next cycle on, and it applies to all planes at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_start | input | 1 | Cell-time strobe; captures the configuration |
| cfg_sel | input | N_PORTS*SW | Per-output source select, field o at [o*SW +: SW], SW = clog2(N_PORTS) |
| cfg_en | input | N_PORTS | Per-output enable for the select field |
| in_cell | input | N_PORTS*CELL_W | Ingress cells, port p at [p*CELL_W +: CELL_W] |
| in_valid | input | N_PORTS | Ingress cell valid per port |
| out_cell | output | N_PORTS*CELL_W | Egress cells, registered, port o at [o*CELL_W +: CELL_W] |
| out_valid | output | N_PORTS | Egress cell valid per port |

## Verification
A configuration capture and a cell transfer can fall in the same cycle. The bench raises `cell_start` with a new permutation in the same cycle in which it presents valid cells. It expects those cells to follow the old mapping and the cells of the following cycle to follow the new one. The scoreboard derives every expected egress vector from its own copy of the configuration, which it updates only after pushing that cycle's expectation. Separately, configuration inputs are changed without a strobe, and the bench confirms at the outputs that routing stays put.

// File: rtl/bsx_pkg.sv
package bsx_pkg;

    localparam int DEF_PORTS  = 4;
    localparam int DEF_PLANES = 4;
    localparam int DEF_CELL_W = 32;

    // Width of one output-select field
    function automatic int sel_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width of one slice when a cell is striped over k planes
    function automatic int slice_bits(input int w, input int k);
        return w / k;
    endfunction

    // Per-output routing state inside a plane
    typedef enum logic [1:0] {
        ROUTE_OFF  = 2'd0,   // output not enabled
        ROUTE_IDLE = 2'd1,   // enabled, but the source has no cell
        ROUTE_LIVE = 2'd2    // enabled and the source has a cell
    } route_e;

endpackage

// File: rtl/bsx_cfg_hold.sv
module bsx_cfg_hold #(
    parameter int N_PORTS = bsx_pkg::DEF_PORTS,
    parameter int SW      = bsx_pkg::sel_bits(N_PORTS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [N_PORTS*SW-1:0] sel_in,
    input  logic [N_PORTS-1:0]    en_in,
    output logic [N_PORTS*SW-1:0] sel_q,
    output logic [N_PORTS-1:0]    en_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            en_q  <= '0;
        end else if (load) begin
            sel_q <= sel_in;
            en_q  <= en_in;
        end
    end

endmodule

// File: rtl/bsx_plane.sv
module bsx_plane #(
    parameter int N_PORTS = bsx_pkg::DEF_PORTS,
    parameter int SLICE_W = 8,
    parameter int SW      = bsx_pkg::sel_bits(N_PORTS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_PORTS*SLICE_W-1:0] in_slice,
    input  logic [N_PORTS-1:0]         in_vld,
    input  logic [N_PORTS*SW-1:0]      sel,
    input  logic [N_PORTS-1:0]         en,
    output logic [N_PORTS*SLICE_W-1:0] out_slice,
    output logic [N_PORTS-1:0]         out_vld
);
    import bsx_pkg::*;

    // One N-to-1 multiplexer per output
    for (genvar o = 0; o < N_PORTS; o++) begin : g_out
        logic [SW-1:0]      src;
        logic [SLICE_W-1:0] pick;
        route_e             state;

        always_comb begin
            src   = sel[o*SW +: SW];
            pick  = '0;
            state = ROUTE_OFF;
            if (en[o] && (int'(src) < N_PORTS)) begin
                if (in_vld[src]) begin
                    state = ROUTE_LIVE;
                    pick  = in_slice[int'(src)*SLICE_W +: SLICE_W];
                end else begin
                    state = ROUTE_IDLE;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                out_slice[o*SLICE_W +: SLICE_W] <= '0;
                out_vld[o]                      <= 1'b0;
            end else if (state == ROUTE_LIVE) begin
                out_slice[o*SLICE_W +: SLICE_W] <= pick;
                out_vld[o]                      <= 1'b1;
            end else begin
                out_slice[o*SLICE_W +: SLICE_W] <= '0;
                out_vld[o]                      <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bsx_reasm.sv
module bsx_reasm #(
    parameter int N_PORTS  = bsx_pkg::DEF_PORTS,
    parameter int N_PLANES = bsx_pkg::DEF_PLANES,
    parameter int SLICE_W  = 8,
    localparam int CELL_W  = SLICE_W * N_PLANES,
    localparam int PLANE_W = N_PORTS * SLICE_W
) (
    input  logic [N_PLANES*PLANE_W-1:0] plane_data,
    input  logic [N_PLANES*N_PORTS-1:0] plane_vld,
    output logic [N_PORTS*CELL_W-1:0]   cell_out,
    output logic [N_PORTS-1:0]          cell_vld
);

    for (genvar o = 0; o < N_PORTS; o++) begin : g_port
        logic [N_PLANES-1:0] col;
        for (genvar i = 0; i < N_PLANES; i++) begin : g_slice
            // Slice i returns to its own position within the cell
            assign cell_out[o*CELL_W + i*SLICE_W +: SLICE_W] =
                plane_data[i*PLANE_W + o*SLICE_W +: SLICE_W];
            assign col[i] = plane_vld[i*N_PORTS + o];
        end
        assign cell_vld[o] = &col;
    end

endmodule

// File: rtl/bitslice_xbar.sv
module bitslice_xbar #(
    parameter int N_PORTS  = bsx_pkg::DEF_PORTS,
    parameter int N_PLANES = bsx_pkg::DEF_PLANES,
    parameter int CELL_W   = bsx_pkg::DEF_CELL_W,
    localparam int SW      = bsx_pkg::sel_bits(N_PORTS),
    localparam int SLICE_W = bsx_pkg::slice_bits(CELL_W, N_PLANES),
    localparam int PLANE_W = N_PORTS * SLICE_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cell_start,
    input  logic [N_PORTS*SW-1:0]     cfg_sel,
    input  logic [N_PORTS-1:0]        cfg_en,
    input  logic [N_PORTS*CELL_W-1:0] in_cell,
    input  logic [N_PORTS-1:0]        in_valid,
    output logic [N_PORTS*CELL_W-1:0] out_cell,
    output logic [N_PORTS-1:0]        out_valid
);

    logic [N_PORTS*SW-1:0]       cfg_sel_q;
    logic [N_PORTS-1:0]          cfg_en_q;
    logic [N_PLANES*PLANE_W-1:0] plane_in;
    logic [N_PLANES*PLANE_W-1:0] plane_out;
    logic [N_PLANES*N_PORTS-1:0] plane_vld;

    bsx_cfg_hold #(.N_PORTS(N_PORTS), .SW(SW)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (cell_start),
        .sel_in (cfg_sel),
        .en_in  (cfg_en),
        .sel_q  (cfg_sel_q),
        .en_q   (cfg_en_q)
    );

    // Striping and one plane per slice, all sharing one configuration
    for (genvar i = 0; i < N_PLANES; i++) begin : g_plane
        for (genvar p = 0; p < N_PORTS; p++) begin : g_stripe
            assign plane_in[i*PLANE_W + p*SLICE_W +: SLICE_W] =
                in_cell[p*CELL_W + i*SLICE_W +: SLICE_W];
        end

        bsx_plane #(.N_PORTS(N_PORTS), .SLICE_W(SLICE_W), .SW(SW)) u_plane (
            .clk       (clk),
            .rst       (rst),
            .in_slice  (plane_in[i*PLANE_W +: PLANE_W]),
            .in_vld    (in_valid),
            .sel       (cfg_sel_q),
            .en        (cfg_en_q),
            .out_slice (plane_out[i*PLANE_W +: PLANE_W]),
            .out_vld   (plane_vld[i*N_PORTS +: N_PORTS])
        );
    end

    bsx_reasm #(.N_PORTS(N_PORTS), .N_PLANES(N_PLANES), .SLICE_W(SLICE_W)) u_reasm (
        .plane_data (plane_out),
        .plane_vld  (plane_vld),
        .cell_out   (out_cell),
        .cell_vld   (out_valid)
    );

endmodule

// File: rtl/bitslice_xbar_chk.sv
module bitslice_xbar_chk #(
    parameter int N_PORTS  = 4,
    parameter int N_PLANES = 4,
    parameter int CELL_W   = 32,
    parameter int SW       = 2
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        cell_start,
    input logic [N_PORTS-1:0]          in_valid,
    input logic [N_PORTS*SW-1:0]       cfg_sel_q,
    input logic [N_PORTS-1:0]          cfg_en_q,
    input logic [N_PLANES*N_PORTS-1:0] plane_vld,
    input logic [N_PORTS*CELL_W-1:0]   out_cell,
    input logic [N_PORTS-1:0]          out_valid
);

    a_r2_cfg_held: assert property (@(posedge clk) disable iff (rst)
        !cell_start |=> ($stable(cfg_sel_q) && $stable(cfg_en_q)));

    a_r7_reset_clears: assert property (@(posedge clk)
        rst |=> (out_valid == '0 && cfg_en_q == '0));

    a_r3_needs_input: assert property (@(posedge clk) disable iff (rst)
        (in_valid == '0) |=> (out_valid == '0));

    for (genvar o = 0; o < N_PORTS; o++) begin : g_o
        logic [N_PLANES-1:0] col;
        for (genvar i = 0; i < N_PLANES; i++) begin : g_i
            assign col[i] = plane_vld[i*N_PORTS + o];
        end

        a_r1_planes_agree: assert property (@(posedge clk) disable iff (rst)
            ($countones(col) == 0) || ($countones(col) == N_PLANES));

        a_r4_disabled_silent: assert property (@(posedge clk) disable iff (rst)
            !cfg_en_q[o] |=> !out_valid[o]);

        a_r5_zero_when_invalid: assert property (@(posedge clk) disable iff (rst)
            !out_valid[o] |-> (out_cell[o*CELL_W +: CELL_W] == '0));
    end

endmodule

bind bitslice_xbar bitslice_xbar_chk #(
    .N_PORTS  (N_PORTS),
    .N_PLANES (N_PLANES),
    .CELL_W   (CELL_W),
    .SW       (SW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cell_start (cell_start),
    .in_valid   (in_valid),
    .cfg_sel_q  (cfg_sel_q),
    .cfg_en_q   (cfg_en_q),
    .plane_vld  (plane_vld),
    .out_cell   (out_cell),
    .out_valid  (out_valid)
);

// File: tb/tb_bitslice_xbar.sv
module tb_bitslice_xbar;
    localparam int N  = 4;
    localparam int K  = 4;
    localparam int W  = 32;
    localparam int SW = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cell_start = 1'b0;
    logic [N*SW-1:0]  cfg_sel = '0;
    logic [N-1:0]     cfg_en = '0;
    logic [N*W-1:0]   in_cell = '0;
    logic [N-1:0]     in_valid = '0;
    logic [N*W-1:0]   out_cell;
    logic [N-1:0]     out_valid;

    always #2 clk = ~clk;   // 250 MHz

    bitslice_xbar #(.N_PORTS(N), .N_PLANES(K), .CELL_W(W)) dut (
        .clk(clk), .rst(rst), .cell_start(cell_start),
        .cfg_sel(cfg_sel), .cfg_en(cfg_en),
        .in_cell(in_cell), .in_valid(in_valid),
        .out_cell(out_cell), .out_valid(out_valid)
    );

    typedef struct {
        logic [N*W-1:0] d;
        logic [N-1:0]   v;
        string          tag;
    } exp_t;

    exp_t sb[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [N*SW-1:0] m_sel = '0;
    logic [N-1:0]    m_en  = '0;

    // Cell whose every slice byte is distinct
    function automatic logic [N*W-1:0] mk(input int seed);
        logic [N*W-1:0] c;
        for (int p = 0; p < N; p++)
            for (int b = 0; b < W/8; b++)
                c[p*W + b*8 +: 8] = 8'((seed * 37) + (p * 16) + (b * 3) + 1);
        return c;
    endfunction

    function automatic logic [N*SW-1:0] perm(input int a, input int b, input int c, input int d);
        return {2'(d), 2'(c), 2'(b), 2'(a)};
    endfunction

    task automatic step(input logic strobe, input logic [N*SW-1:0] nsel,
                        input logic [N-1:0] nen, input logic [N*W-1:0] cells,
                        input logic [N-1:0] vld, input string tag);
        exp_t e;
        @(negedge clk);
        cell_start = strobe;
        cfg_sel    = nsel;
        cfg_en     = nen;
        in_cell    = cells;
        in_valid   = vld;
        e.d = '0; e.v = '0; e.tag = tag;
        for (int o = 0; o < N; o++) begin
            int s;
            s = int'(m_sel[o*SW +: SW]);
            if (m_en[o] && vld[s]) begin
                e.d[o*W +: W] = cells[s*W +: W];
                e.v[o] = 1'b1;
            end
        end
        sb.push_back(e);
        if (strobe) begin
            m_sel = nsel;
            m_en  = nen;
        end
    endtask

    // Monitor: compares each registered result against its expectation
    always @(posedge clk) begin
        #1;
        if (!rst && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (out_cell !== e.d || out_valid !== e.v) begin
                n_fail++;
                $display("FAIL %s: got cell=%h valid=%b, expected cell=%h valid=%b",
                         e.tag, out_cell, out_valid, e.d, e.v);
            end
        end
    end

    task automatic drain;
        step(1'b0, '0, '0, '0, '0, "idle");
        while (sb.size() > 0) @(posedge clk);
        #2;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got no completion, expected completion");
        finish_run();
    end

    initial begin
        logic [N*SW-1:0] ident;
        logic [N*SW-1:0] rev;
        ident = perm(0, 1, 2, 3);
        rev   = perm(3, 2, 1, 0);

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R7: reset state at the ports
        n_checks++;
        if (out_cell !== '0 || out_valid !== '0) begin
            n_fail++;
            $display("FAIL R7 reset: got cell=%h valid=%b, expected all zero", out_cell, out_valid);
        end

        // R8: strobe with data; old (cleared) configuration routes this cell
        step(1'b1, ident, 4'hF, mk(1), 4'hF, "R8 strobe cycle uses old cfg");
        // R3 / R1: identity routing with distinct slices
        step(1'b0, ident, 4'hF, mk(2), 4'hF, "R3 R1 identity");
        // R2: cfg inputs change without strobe, routing must stay identity
        step(1'b0, rev, 4'h0, mk(3), 4'hF, "R2 no strobe ignored");
        step(1'b0, perm(2, 2, 2, 2), 4'h5, mk(4), 4'hF, "R2 no strobe ignored");
        // R8: new permutation captured together with a cell
        step(1'b1, rev, 4'hF, mk(5), 4'hF, "R8 capture with data");
        step(1'b0, rev, 4'hF, mk(6), 4'hF, "R3 R1 reversed");
        step(1'b0, ident, 4'h3, mk(7), 4'hF, "R3 reversed held");
        // R6: multicast of input 2 to every output
        step(1'b1, perm(2, 2, 2, 2), 4'hF, mk(8), 4'hF, "R8 before multicast");
        step(1'b0, '0, '0, mk(9), 4'hF, "R6 multicast");
        // R4: outputs 1 and 3 disabled
        step(1'b1, perm(1, 2, 3, 0), 4'h5, mk(10), 4'hF, "R6 multicast held");
        step(1'b0, '0, '0, mk(11), 4'hF, "R4 disabled outputs");
        // R5: selected source invalid
        step(1'b1, perm(1, 2, 3, 0), 4'hF, mk(12), 4'hF, "R4 disabled held");
        step(1'b0, '0, '0, mk(13), 4'b0101, "R5 invalid source");
        step(1'b0, '0, '0, mk(14), 4'b1010, "R5 invalid source");
        step(1'b0, '0, '0, mk(15), 4'b0000, "R5 no input");
        drain();

        // R7: mid-run reset clears the held configuration
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_sel = '0;
        m_en  = '0;
        n_checks++;
        if (out_cell !== '0 || out_valid !== '0) begin
            n_fail++;
            $display("FAIL R7 mid-run reset: got cell=%h valid=%b, expected all zero", out_cell, out_valid);
        end
        step(1'b0, ident, 4'hF, mk(16), 4'hF, "R7 cfg cleared by reset");
        step(1'b1, perm(3, 3, 0, 1), 4'hF, mk(17), 4'hF, "R8 after reset");
        step(1'b0, '0, '0, mk(18), 4'hF, "R6 R1 after reset");
        drain();

        finish_run();
    end

endmodule